// File: doc/BRIEF.md
# Pulse-Added PWM Generator

This block drives a single PWM output from an internal timer. A short base counter sets a base waveform whose high time is taken from the low field of a compare word. Base periods are grouped into frames. Within each frame, a chosen set of base periods is stretched by one extra tick of high time. The set is chosen by the high field of the compare word. Averaged over a frame, the duty cycle therefore has the resolution of the whole compare word, while the output period stays as short as one base period.

The timer advances on ticks from one of four sources. The sources are the block clock itself, the clock divided by 4, the clock divided by 16, or the rising edge of an external pin, which is first synchronised. The stretched periods are spread evenly over the frame. A period index is stretched when its bit-reversed value is below the high field.

Compare values written while the timer runs wait for the next frame boundary. The tick source is taken only while the block is disabled. Turning the enable on therefore never merges with a change of the other settings into a stray count.

Top module: `padd_pwm`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `pwm_o` is 0. Reset clears the base count and the period index to 0.
- R2: While disabled, `pwm_o` is 0, from the second clock edge after `run_en_i` is sampled low. The base count and the period index are held at 0. The compare word and tick source are copied from the inputs on every cycle.
- R3: A base period lasts 2^BASE_W ticks. In a period that is not stretched, the output is high for exactly D ticks, where D = `cmp_i[BASE_W-1:0]`, with D = 0 giving no high time.
- R4: A stretched period is high for D+1 ticks. The extra tick is the one where the base count equals D, so D at its maximum gives a fully high period.
- R5: Let A = `cmp_i[BASE_W+FRAME_W-1:BASE_W]`. Period index k (0 to 2^FRAME_W-1 within a frame) is stretched exactly when the bit-reversed k is less than A. A frame therefore holds A stretched periods and 2^FRAME_W·D + A high ticks.
- R6: A compare word changed while enabled is ignored for the rest of the current frame. It is captured on the tick that wraps both the base count and the period index, and it governs the frame that follows.
- R7: `clk_sel_i` picks the tick: 0 = every clock, 1 = every 4th clock, 2 = every 16th clock, 3 = a rising edge on `ext_clk_i`. For source 3 the count changes on the third rising clock edge after the pin goes high.
- R8: Changes to `clk_sel_i` while enabled have no effect until the block has been disabled for at least one cycle.
- R9: When `run_en_i` is first sampled high, the frame starts at count 0, index 0, and the prescaler is cleared. `pwm_o` follows the timer state with one register of delay. For source 0 the first count advance is on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Enable; low stops and clears the timer |
| cmp_i | input | BASE_W+FRAME_W | Compare word: low field base duty, high field stretch amount |
| clk_sel_i | input | 2 | Tick source select |
| ext_clk_i | input | 1 | External tick pin, asynchronous |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with BASE_W = 4 and FRAME_W = 3. A frame is then only 128 ticks long, so whole frames fit in the run under every tick source, even the divide-by-16 one. These sizes bring several cases within reach: per-period high counts against the bit-reversed stretch rule, a compare change in the middle of a frame deferred to the frame boundary, and the edge cases of zero and full duty. A behavioural model with its own integer state is compared with the output on every clock. Whole-frame high counts are also checked against the closed-form totals.

// File: rtl/padd_pwm_pkg.sv
package padd_pwm_pkg;

    // Tick source encoding, matches the clk_sel_i port values
    typedef enum logic [1:0] {
        SRC_FAST   = 2'd0,
        SRC_DIV_LO = 2'd1,
        SRC_DIV_HI = 2'd2,
        SRC_PIN    = 2'd3
    } tick_src_e;

endpackage

// File: rtl/padd_tick_gen.sv
module padd_tick_gen
    import padd_pwm_pkg::*;
#(
    parameter int DIV_LO_LOG = 2,
    parameter int DIV_HI_LOG = 4
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      run_i,
    input  tick_src_e src_i,
    input  logic      pin_i,
    output logic      tick_o
);

    localparam int PRE_W  = DIV_HI_LOG;
    localparam int SYNC_N = 3;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [SYNC_N-1:0] sync;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      pin_rise;

    // sync[1] is the settled pin level, sync[2] the level one cycle earlier
    assign pin_rise = st_q.sync[1] & ~st_q.sync[2];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], pin_i};
        if (run_i) begin
            st_d.pre = st_q.pre + 1'b1;
        end else begin
            st_d.pre = '0;
        end

        unique case (src_i)
            SRC_FAST:   tick_o = run_i;
            SRC_DIV_LO: tick_o = run_i & (&st_q.pre[DIV_LO_LOG-1:0]);
            SRC_DIV_HI: tick_o = run_i & (&st_q.pre);
            SRC_PIN:    tick_o = run_i & pin_rise;
            default:    tick_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    div_hi_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i == SRC_DIV_HI && tick_o) |=> !tick_o)
        else $error("divided tick repeated on consecutive cycles");

    // R7
    pin_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i == SRC_PIN && tick_o) |=> !tick_o)
        else $error("pin edge produced two ticks");

endmodule

// File: rtl/padd_stretch.sv
module padd_stretch #(
    parameter int FRAME_W = 8
) (
    input  logic [FRAME_W-1:0] idx_i,
    input  logic [FRAME_W-1:0] amount_i,
    output logic               stretch_o
);

    logic [FRAME_W-1:0] idx_rev;

    generate
        for (genvar g = 0; g < FRAME_W; g++) begin : g_rev
            assign idx_rev[g] = idx_i[FRAME_W-1-g];
        end
    endgenerate

    assign stretch_o = (idx_rev < amount_i);

    always_comb begin
        // R5
        if (amount_i == '0) begin
            zero_amt_chk: assert (!stretch_o)
                else $error("period stretched with zero amount");
        end
        // R5
        if (amount_i == '1 && idx_i != '1) begin
            full_amt_chk: assert (stretch_o)
                else $error("period not stretched with full amount");
        end
    end

endmodule

// File: rtl/padd_core.sv
module padd_core
    import padd_pwm_pkg::*;
#(
    parameter int BASE_W  = 8,
    parameter int FRAME_W = 8
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      en_i,
    input  logic [BASE_W+FRAME_W-1:0] cmp_i,
    input  tick_src_e                 src_i,
    input  logic                      tick_i,
    output logic                      en_o,
    output tick_src_e                 src_o,
    output logic [BASE_W-1:0]         cnt_o,
    output logic [FRAME_W-1:0]        idx_o,
    output logic [BASE_W-1:0]         duty_o,
    output logic [FRAME_W-1:0]        amt_o
);

    typedef struct packed {
        logic               en;
        tick_src_e          src;
        logic [BASE_W-1:0]  cnt;
        logic [FRAME_W-1:0] idx;
        logic [BASE_W-1:0]  duty;
        logic [FRAME_W-1:0] amt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        cnt_last, idx_last;

    assign cnt_last = &st_q.cnt;
    assign idx_last = &st_q.idx;

    always_comb begin
        st_d    = st_q;
        st_d.en = en_i;

        // Shadow copies follow the inputs only while stopped
        if (!st_q.en) begin
            st_d.duty = cmp_i[BASE_W-1:0];
            st_d.amt  = cmp_i[BASE_W +: FRAME_W];
            st_d.src  = src_i;
        end

        if (!en_i || !st_q.en) begin
            st_d.cnt = '0;
            st_d.idx = '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (cnt_last) begin
                st_d.idx = st_q.idx + 1'b1;
                if (idx_last) begin
                    st_d.duty = cmp_i[BASE_W-1:0];
                    st_d.amt  = cmp_i[BASE_W +: FRAME_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign src_o  = st_q.src;
    assign cnt_o  = st_q.cnt;
    assign idx_o  = st_q.idx;
    assign duty_o = st_q.duty;
    assign amt_o  = st_q.amt;

    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && $past(st_q.en)) |->
            (BASE_W'(st_q.cnt - $past(st_q.cnt)) <= BASE_W'(1)))
        else $error("base count jumped");

    // R5
    idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && $past(st_q.en) && !$stable(st_q.idx)) |-> (st_q.cnt == '0))
        else $error("period index moved off a period boundary");

    // R6
    shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && $past(st_q.en) && (st_q.cnt != '0 || st_q.idx != '0)) |->
            ($stable(st_q.duty) && $stable(st_q.amt)))
        else $error("compare shadow changed inside a frame");

    // R8
    sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.en |=> $stable(st_q.src))
        else $error("tick source changed while running");

    // R2
    idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.en |=> (st_q.cnt == '0 && st_q.idx == '0))
        else $error("timer not held at zero while stopped");

endmodule

// File: rtl/padd_out.sv
module padd_out #(
    parameter int BASE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [BASE_W-1:0] cnt_i,
    input  logic [BASE_W-1:0] duty_i,
    input  logic              stretch_i,
    output logic              pwm_o
);

    typedef struct packed {
        logic pwm;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = en_i & ((cnt_i < duty_i) | ((cnt_i == duty_i) & stretch_i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/padd_pwm.sv
module padd_pwm
    import padd_pwm_pkg::*;
#(
    parameter int BASE_W     = 8,
    parameter int FRAME_W    = 8,
    parameter int DIV_LO_LOG = 2,
    parameter int DIV_HI_LOG = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      run_en_i,
    input  logic [BASE_W+FRAME_W-1:0] cmp_i,
    input  logic [1:0]                clk_sel_i,
    input  logic                      ext_clk_i,
    output logic                      pwm_o
);

    logic               core_en;
    tick_src_e          core_src;
    logic [BASE_W-1:0]  cnt;
    logic [FRAME_W-1:0] idx;
    logic [BASE_W-1:0]  duty;
    logic [FRAME_W-1:0] amt;
    logic               tick;
    logic               stretch;

    padd_tick_gen #(
        .DIV_LO_LOG (DIV_LO_LOG),
        .DIV_HI_LOG (DIV_HI_LOG)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (core_en),
        .src_i  (core_src),
        .pin_i  (ext_clk_i),
        .tick_o (tick)
    );

    padd_core #(
        .BASE_W  (BASE_W),
        .FRAME_W (FRAME_W)
    ) u_core (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (run_en_i),
        .cmp_i  (cmp_i),
        .src_i  (tick_src_e'(clk_sel_i)),
        .tick_i (tick),
        .en_o   (core_en),
        .src_o  (core_src),
        .cnt_o  (cnt),
        .idx_o  (idx),
        .duty_o (duty),
        .amt_o  (amt)
    );

    padd_stretch #(
        .FRAME_W (FRAME_W)
    ) u_stretch (
        .idx_i     (idx),
        .amount_i  (amt),
        .stretch_o (stretch)
    );

    padd_out #(
        .BASE_W (BASE_W)
    ) u_out (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (core_en),
        .cnt_i     (cnt),
        .duty_i    (duty),
        .stretch_i (stretch),
        .pwm_o     (pwm_o)
    );

    // R2
    out_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(core_en) |-> !pwm_o)
        else $error("output high after a stopped cycle");

    // R3
    zero_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(duty) == '0 && $past(cnt) != '0) |-> !pwm_o)
        else $error("output high past a zero duty");

endmodule

// File: tb/padd_pwm_tb_top.sv
`timescale 1ns/1ps
module padd_pwm_tb_top;

    localparam int BW = 4;
    localparam int FW = 3;
    localparam int NB = 16;
    localparam int NF = 8;
    localparam int CW = BW + FW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          ext = 1'b0;
    logic [CW-1:0] cmp = '0;
    logic [1:0]    sel = 2'd0;
    logic          pwm;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cmp_on = 0;
    int    ext_run = 0;
    int    ext_cnt = 0;
    int    done = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    padd_pwm #(.BASE_W(BW), .FRAME_W(FW)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .run_en_i  (en),
        .cmp_i     (cmp),
        .clk_sel_i (sel),
        .ext_clk_i (ext),
        .pwm_o     (pwm)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int brev(int k);
        int r = 0;
        for (int i = 0; i < FW; i++) begin
            if (((k >> i) & 1) != 0) r = r | (1 << (FW - 1 - i));
        end
        return r;
    endfunction

    // Behavioural reference
    int m_en, m_cnt, m_idx, m_duty, m_amt, m_sel, m_pre, m_s1, m_s2, m_s3, m_pwm;
    int t_tick, t_pwm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_idx = 0; m_duty = 0; m_amt = 0; m_sel = 0;
            m_pre = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pwm = 0;
        end else begin
            t_tick = 0;
            if (m_en != 0) begin
                case (m_sel)
                    0: t_tick = 1;
                    1: t_tick = (m_pre % 4 == 3) ? 1 : 0;
                    2: t_tick = (m_pre == 15) ? 1 : 0;
                    default: t_tick = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
                endcase
            end
            t_pwm = 0;
            if (m_en != 0 && (m_cnt < m_duty || (m_cnt == m_duty && brev(m_idx) < m_amt)))
                t_pwm = 1;
            m_pwm = t_pwm;
            m_pre = (m_en != 0) ? (m_pre + 1) % 16 : 0;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext);
            if (!en || m_en == 0) begin
                m_cnt = 0; m_idx = 0;
            end else if (t_tick != 0) begin
                if (m_cnt == NB - 1) begin
                    m_cnt = 0;
                    if (m_idx == NF - 1) begin
                        m_idx = 0;
                        m_duty = int'(cmp) % NB;
                        m_amt = int'(cmp) / NB;
                    end else begin
                        m_idx++;
                    end
                end else begin
                    m_cnt++;
                end
            end
            if (m_en == 0) begin
                m_duty = int'(cmp) % NB;
                m_amt = int'(cmp) / NB;
                m_sel = int'(sel);
            end
            m_en = int'(en);
        end
    end

    // Compare with the reference on every clock
    always @(posedge clk) begin
        #2;
        if (cmp_on != 0 && done == 0) chk(phase, int'(pwm), m_pwm);
    end

    // External pin stimulus
    always @(negedge clk) begin
        if (ext_run != 0) begin
            ext_cnt++;
            if (ext_cnt == 3) begin
                ext_cnt = 0;
                ext = ~ext;
            end
        end
    end

    // One frame of samples; per-period and whole-frame high counts
    task automatic run_frame(int mult, int duty, int amt, int change_at, int new_cmp, string tag);
        int tot = 0;
        int per = 0;
        int plen = NB * mult;
        for (int i = 0; i < NF * plen; i++) begin
            @(posedge clk);
            #3;
            per += int'(pwm);
            tot += int'(pwm);
            if (i == change_at) cmp = CW'(new_cmp);
            if ((i % plen) == plen - 1) begin
                int j = i / plen;
                int st = (brev(j) < amt) ? 1 : 0;
                // R4 for stretched periods, R3 otherwise
                chk(st != 0 ? "R4" : "R3", per, mult * (duty + st));
                per = 0;
            end
        end
        chk(tag, tot, mult * (NF * duty + amt));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3;
        chk("R1", int'(pwm), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(posedge clk);
        #3;
        chk("R1", int'(pwm), 0);

        // Idle with settings applied
        phase = "R2";
        cmp = 7'h35;
        sel = 2'd0;
        repeat (5) @(negedge clk);
        chk("R2", int'(pwm), 0);

        // Start: duty 5, amount 3
        en = 1'b1;
        phase = "R9";
        @(posedge clk);
        run_frame(1, 5, 3, -1, 0, "R5");

        // Mid-frame compare change deferred to next frame
        phase = "R6";
        run_frame(1, 5, 3, 20, 7'h79, "R6");

        // Select change while running is ignored
        phase = "R8";
        sel = 2'd2;
        run_frame(1, 9, 7, -1, 0, "R8");

        // Disable: output low, new settings captured
        @(negedge clk);
        en = 1'b0;
        phase = "R2";
        cmp = 7'h4F;
        repeat (2) @(posedge clk);
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            #3;
            chk("R2", int'(pwm), 0);
        end

        // Divide-by-16 source, full duty
        @(negedge clk);
        en = 1'b1;
        phase = "R7";
        @(posedge clk);
        run_frame(16, 15, 4, -1, 0, "R7");

        // Divide-by-4 source, zero duty
        @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        sel = 2'd1;
        cmp = 7'h20;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        run_frame(4, 0, 2, -1, 0, "R7");

        // External pin source, zero amount
        @(negedge clk);
        en = 1'b0;
        sel = 2'd3;
        cmp = 7'h08;
        ext_run = 1;
        repeat (3) @(negedge clk);
        en = 1'b1;
        phase = "R7";
        repeat (2000) @(posedge clk);

        // Reset while running
        @(negedge clk);
        phase = "R1";
        rst_n = 1'b0;
        @(posedge clk);
        #3;
        chk("R1", int'(pwm), 0);
        ext_run = 0;
        repeat (2) @(posedge clk);
        done = 1;
        #1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (done == 0) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule